// File: doc/BRIEF.md
# Edge-latched interrupt status controller

This block gathers six interrupt source lines into a sticky status word and raises one level-sensitive interrupt request. Each source line is treated as asynchronous: it passes through a synchroniser chain, then a rising-edge detector. A rising edge on a source whose enable bit is set sets that source's status bit to 1, and the bit stays set until software clears the enable bit for that source. There is no separate acknowledge or clear register. Clearing the enable bit is the only way to clear the status bit.

The request output follows the whole status word. It goes high when the word moves from all-zero to any non-zero value. It stays high until every status bit has been cleared again.

A small register port gives access to the block. Address 0 holds the enable mask, which is read/write. Address 1 holds the status word, which is read-only. The status word is also driven continuously on a separate digital-input port, one bit per source. This lets the word be sampled directly as an input word.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the enable mask (address 0) reads 0, the status word (address 1) reads 0, din_o is 0 and irq_o is low.
- R2: A 0-to-1 change on src_i[k] with enable bit k set appears as status bit k = 1 right after the third rising clock edge that follows the change. This is two synchroniser stages plus the edge detector. The bit still reads 0 after the second edge.
- R3: A rising edge on a source whose enable bit is 0 does not set its status bit. Setting the enable bit while the source is already high does not set its status bit either.
- R4: Writing 0 to enable bit k clears status bit k at the same clock edge. If a rising edge on source k is pending in that same cycle, the clear wins and the bit reads 0. A status bit is never 1 while its enable bit is 0.
- R5: irq_o rises at the edge where the status word goes from all-zero to non-zero. It stays high while any status bit is set, and it falls at the edge where the word returns to zero.
- R6: When we_i is high at a clock edge and addr_i = 0, wdata_i is loaded into the enable mask. rdata_o shows the enable mask when addr_i = 0 and the status word when addr_i = 1. A write with addr_i = 1 changes neither register.
- R7: din_o always equals the status word read at address 1, with bit k belonging to source k.
- R8: A status bit that is set stays set while its enable bit stays 1, whatever its source does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 6 | Asynchronous interrupt source lines |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address (0 enable, 1 status) |
| wdata_i | input | 6 | Register write data |
| rdata_o | output | 6 | Register read data, combinational on addr_i |
| din_o | output | 6 | Status word as a digital-input word |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: six sources and a two-stage synchroniser. This makes the exact three-edge latency from a source change to its status bit a fixed, checkable number. With only six sources, a random mix of source toggles and enable writes keeps hitting the rare cases. These include a disable landing in the same cycle as an edge, an enable written while a source is already high, and the status word falling back to zero. Directed sequences pin down each of those cases once, and a cycle-by-cycle bench model checks the random run.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned ADDR_W   = 1;
  localparam logic [ADDR_W-1:0] ADDR_EN = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_ST = 1'b1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  input  logic [WIDTH-1:0] rise_i,
  output logic [WIDTH-1:0] en_o,
  output logic [WIDTH-1:0] st_o,
  output logic [WIDTH-1:0] st_next_o
);
  logic [WIDTH-1:0] en_q, en_d, st_q, st_d;

  assign en_d = en_we_i ? en_wdata_i : en_q;
  // Edge counts only if enabled now; masking with next enable makes clear win.
  assign st_d = (st_q | (rise_i & en_q)) & en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign en_o      = en_q;
  assign st_o      = st_q;
  assign st_next_o = st_d;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] st_i,
  input  logic [WIDTH-1:0] st_next_i,
  output logic             irq_o
);
  logic irq_q;
  logic now_zero, next_zero;
  assign now_zero  = (st_i == '0);
  assign next_zero = (st_next_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     irq_q <= 1'b0;
    else if (now_zero && !next_zero) irq_q <= 1'b1;
    else if (next_zero)              irq_q <= 1'b0;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic [NUM_SRC-1:0] din_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_sync, src_rise;
  logic [NUM_SRC-1:0] en_q, st_q, st_d;
  logic               en_we;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(src_i), .q_o(src_sync)
  );

  irq_edge_det #(.WIDTH(NUM_SRC)) u_edge (
    .clk_i, .rst_ni, .lvl_i(src_sync), .rise_o(src_rise)
  );

  assign en_we = we_i && (addr_i == ADDR_EN);

  irq_status_reg #(.WIDTH(NUM_SRC)) u_status (
    .clk_i, .rst_ni,
    .en_we_i(en_we), .en_wdata_i(wdata_i), .rise_i(src_rise),
    .en_o(en_q), .st_o(st_q), .st_next_o(st_d)
  );

  irq_req_gen #(.WIDTH(NUM_SRC)) u_req (
    .clk_i, .rst_ni, .st_i(st_q), .st_next_i(st_d), .irq_o(irq_o)
  );

  assign rdata_o = (addr_i == ADDR_ST) ? st_q : en_q;
  assign din_o   = st_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned NUM_SRC = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] st_i,
  input logic [NUM_SRC-1:0] din_i,
  input logic               irq_i
);
  assert_irq_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (st_i != '0));

  assert_no_bit_without_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i & ~en_i) == '0);

  assert_din_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_i == st_i);

  assert_sticky_while_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(st_i) & en_i) & ~st_i) == '0);

  assert_set_needs_prior_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i & ~$past(st_i)) & ~$past(en_i)) == '0);
endmodule

bind irq_status_ctrl irq_status_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .st_i(st_q),
  .din_i(din_o), .irq_i(irq_o)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0, wdata = '0;
  logic we = 1'b0;
  logic [0:0] addr = 1'b0;
  logic [N-1:0] rdata, din;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .din_o(din), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_p, m_en, m_st;
  logic m_irq;
  function automatic logic [N-1:0] next_st(input logic [N-1:0] st, rise, en, en_n);
    return (st | (rise & en)) & en_n;
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_p = '0; m_en = '0; m_st = '0; m_irq = 0;
    end else begin
      logic [N-1:0] rise, en_n, st_n;
      rise = m_s2 & ~m_p;
      en_n = (we && addr == 1'b0) ? wdata : m_en;
      st_n = next_st(m_st, rise, m_en, en_n);
      if (m_st == '0 && st_n != '0) m_irq = 1;
      else if (st_n == '0) m_irq = 0;
      m_p = m_s2; m_s2 = m_s1; m_s1 = src;
      m_en = en_n; m_st = st_n;
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [N-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'h5eed));
    tick(3); rst_n = 1; tick(1);
    // R1 reset state
    rd(0, v); chk("R1 enable", v, '0);
    rd(1, v); chk("R1 status", v, '0);
    chk("R1 din", din, '0); chk("R1 irq", {5'b0, irq}, '0);
    // R6 write/read, addr1 write ignored
    wr(0, 6'h05);
    rd(0, v); chk("R6 enable readback", v, 6'h05);
    wr(1, 6'h3f);
    rd(1, v); chk("R6 status unwritable", v, '0);
    rd(0, v); chk("R6 enable untouched", v, 6'h05);
    // R2 latency
    src[0] = 1; tick(2);
    rd(1, v); chk("R2 not yet after 2 edges", v, '0);
    tick(1);
    rd(1, v); chk("R2 set after 3 edges", v, 6'h01);
    chk("R5 irq high", {5'b0, irq}, 6'h01);
    chk("R7 din mirrors", din, 6'h01);
    // R8 sticky
    src[0] = 0; tick(5);
    rd(1, v); chk("R8 sticky", v, 6'h01);
    // R3 disabled edge and enable while high
    src[1] = 1; tick(5);
    rd(1, v); chk("R3 disabled edge", v, 6'h01);
    wr(0, 6'h07); tick(4);
    rd(1, v); chk("R3 enable while high", v, 6'h01);
    // R5 irq stays while another bit joins
    src[2] = 1; tick(3);
    rd(1, v); chk("R5 second bit", v, 6'h05);
    chk("R5 irq held", {5'b0, irq}, 6'h01);
    src[2] = 0; tick(2);
    // R4 disable clears
    wr(0, 6'h06);
    rd(1, v); chk("R4 clear by disable", v, 6'h04);
    wr(0, 6'h02);
    rd(1, v); chk("R4 all cleared", v, '0);
    chk("R5 irq low at zero", {5'b0, irq}, '0);
    // R4 clear wins over coincident edge
    wr(0, 6'h06); tick(3);
    src[2] = 1; tick(2);
    wr(0, 6'h02);
    rd(1, v); chk("R4 clear precedence", v, '0);
    chk("R4 irq stays low", {5'b0, irq}, '0);
    src = '0; tick(4);
    // random run against model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) src[$urandom_range(N-1)] ^= 1'b1;
      if ($urandom_range(7) == 0) begin
        addr = 1'($urandom_range(1)); wdata = N'($urandom); we = 1;
      end else begin
        we = 0; addr = 1'($urandom_range(1));
      end
      @(negedge clk);
      we = 0;
      rd(0, v); chk("R6 rand enable", v, m_en);
      rd(1, v); chk("R2 rand status", v, m_st);
      chk("R7 rand din", din, m_st);
      chk("R5 rand irq", {5'b0, irq}, {5'b0, m_irq});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule